// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel NOR flash model. Each accepted write strobe carries a command address and a data byte. The block matches these strobes against unlock-prefixed command sequences. Every sequence opens with the same two key writes. The third byte then picks the branch: it arms a byte program, it opens a longer erase prefix, it switches the readout mode, or it leaves that mode.

Each recognised command raises one request pulse for a single clock. The pulse carries a kind code together with the latched address and data. The block also tracks whether reads return array data, identification bytes or query data, and it serves the two identification bytes itself. A busy input from the program/erase engine makes every write invisible while it is high. Any write that breaks a sequence drops the partial sequence and forces plain read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Out of reset the mode is read (mode code 0), req_valid is low, id_valid is low and no partial sequence is pending.
- R2: Every command begins with data AAh at command address 5555h and then 55h at 2AAAh. Only wr_addr bits 14..0 take part in the comparison, so higher address bits have no effect on matching.
- R3: A third write of A0h at 5555h arms a program. The following write, at any address, yields a request with kind 1 that carries the full address and data of that fourth write.
- R4: The prefix AAh/55h, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, followed by a sixth write of 10h at 5555h, yields a request with kind 4 (whole-array erase).
- R5: The same five-write erase prefix followed by 30h yields kind 2. Its req_addr is the sixth write's address with bits 11..0 forced to zero, which selects a 4 KB sector.
- R6: The same five-write erase prefix followed by 50h yields kind 3. Its req_addr is the sixth write's address with bits 15..0 forced to zero, which selects a 64 KB block.
- R7: A third write of 90h at 5555h yields kind 5 and sets mode 1 (identification). A third write of 98h at 5555h yields kind 6 and sets mode 2 (query).
- R8: The exit command yields kind 7 and sets mode 0. It is accepted in two forms: a lone write of F0h at any address when no sequence is pending, or F0h at 5555h as the third write after the unlock pair.
- R9: A write that does not match the expected address and data produces no request, sets mode 0 and clears the partial sequence. A following correct sequence is then recognised from its first write.
- R10: While busy is high, a write changes nothing. That includes exit and writes in the middle of a sequence, and no request is raised.
- R11: In mode 1, rd_addr 0 gives id_data BFh and rd_addr 1 gives the parameter DEV_CODE (default D8h), both with id_valid high. At any other address, or in any other mode, id_valid is low.
- R12: Each recognised command raises req_valid for exactly one clock, one cycle after the write that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One qualified write strobe this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Internal program/erase running; writes ignored |
| rd_addr | input | AW | Read address for identification readout |
| mode | output | 2 | 0 read, 1 identification, 2 query |
| req_valid | output | 1 | Single-cycle command request |
| req_kind | output | 3 | 1 program, 2 sector, 3 block, 4 chip, 5 id on, 6 query on, 7 exit |
| req_addr | output | AW | Latched address (erase addresses aligned) |
| req_data | output | 8 | Latched data byte |
| id_valid | output | 1 | id_data holds an identification byte |
| id_data | output | 8 | Identification byte |

## Verification
A busy strobe can land in the same cycle as a write that would complete or advance a sequence. Two cases provoke this. In the first, a lone exit write is issued in identification mode with busy high, and the mode and request lines are expected to stay as they were. In the second, busy is raised with a junk write in the middle of a program sequence, and the sequence is then finished once busy drops. That case is judged correct only if the program request still appears with the fourth write's address and data, which shows that the suppressed write neither aborted the sequence nor advanced it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [1:0] {
      MODE_READ  = 2'd0,
      MODE_ID    = 2'd1,
      MODE_QUERY = 2'd2
   } fl_mode_e;

   typedef enum logic [2:0] {
      REQ_NONE     = 3'd0,
      REQ_PROGRAM  = 3'd1,
      REQ_SECTOR   = 3'd2,
      REQ_BLOCK    = 3'd3,
      REQ_CHIP     = 3'd4,
      REQ_ID_ON    = 3'd5,
      REQ_QUERY_ON = 3'd6,
      REQ_EXIT     = 3'd7
   } fl_req_e;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_KEY1  = 3'd1,
      SQ_KEY2  = 3'd2,
      SQ_ARMED = 3'd3,
      SQ_ER3   = 3'd4,
      SQ_ER4   = 3'd5,
      SQ_ER5   = 3'd6
   } seq_state_e;

   localparam int          CMP_BITS   = 15;
   localparam logic [14:0] CMD_ADDR_A = 15'h5555;
   localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;

   localparam logic [7:0] CODE_KEY1    = 8'hAA;
   localparam logic [7:0] CODE_KEY2    = 8'h55;
   localparam logic [7:0] CODE_PROG    = 8'hA0;
   localparam logic [7:0] CODE_ERSETUP = 8'h80;
   localparam logic [7:0] CODE_CHIP    = 8'h10;
   localparam logic [7:0] CODE_SECTOR  = 8'h30;
   localparam logic [7:0] CODE_BLOCK   = 8'h50;
   localparam logic [7:0] CODE_ID_ON   = 8'h90;
   localparam logic [7:0] CODE_QRY_ON  = 8'h98;
   localparam logic [7:0] CODE_EXIT    = 8'hF0;
   localparam logic [7:0] CODE_MFR     = 8'hBF;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
   import fcd_pkg::*;
#(
   parameter int AW = 20
) (
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   output logic          at_a,
   output logic          at_b,
   output logic          key1,
   output logic          key2,
   output logic          c_prog,
   output logic          c_setup,
   output logic          c_id,
   output logic          c_query,
   output logic          c_exit,
   output logic          c_chip,
   output logic          c_sector,
   output logic          c_block
);

   logic [CMP_BITS-1:0] cmp_addr;

   // Only the low command bits are compared; upper address lines are free.
   assign cmp_addr = wr_addr[CMP_BITS-1:0];

   always_comb begin
      at_a     = (cmp_addr == CMD_ADDR_A);
      at_b     = (cmp_addr == CMD_ADDR_B);
      key1     = at_a && (wr_data == CODE_KEY1);
      key2     = at_b && (wr_data == CODE_KEY2);
      c_prog   = (wr_data == CODE_PROG);
      c_setup  = (wr_data == CODE_ERSETUP);
      c_id     = (wr_data == CODE_ID_ON);
      c_query  = (wr_data == CODE_QRY_ON);
      c_exit   = (wr_data == CODE_EXIT);
      c_chip   = (wr_data == CODE_CHIP);
      c_sector = (wr_data == CODE_SECTOR);
      c_block  = (wr_data == CODE_BLOCK);
   end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import fcd_pkg::*;
#(
   parameter int AW          = 20,
   parameter int SECTOR_BITS = 12,
   parameter int BLOCK_BITS  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic          busy,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          at_a,
   input  logic          key1,
   input  logic          key2,
   input  logic          c_prog,
   input  logic          c_setup,
   input  logic          c_id,
   input  logic          c_query,
   input  logic          c_exit,
   input  logic          c_chip,
   input  logic          c_sector,
   input  logic          c_block,
   output logic          ev_read,
   output logic          ev_id,
   output logic          ev_query,
   output logic          req_valid,
   output logic [2:0]    req_kind,
   output logic [AW-1:0] req_addr,
   output logic [7:0]    req_data
);

   localparam logic [AW-1:0] SEC_MASK = {AW{1'b1}} << SECTOR_BITS;
   localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << BLOCK_BITS;

   seq_state_e    st, st_nxt;
   logic          take;
   logic          fire;
   fl_req_e       kind_nxt;
   logic [AW-1:0] addr_nxt;

   assign take = wr_valid && !busy;

   always_comb begin
      st_nxt   = st;
      fire     = 1'b0;
      kind_nxt = REQ_NONE;
      addr_nxt = wr_addr;
      ev_read  = 1'b0;
      ev_id    = 1'b0;
      ev_query = 1'b0;
      if (take) begin
         // default outcome of any write: abort to idle and read mode
         st_nxt  = SQ_IDLE;
         ev_read = 1'b1;
         unique case (st)
            SQ_IDLE: begin
               if (key1) begin
                  st_nxt  = SQ_KEY1;
                  ev_read = 1'b0;
               end else if (c_exit) begin
                  fire     = 1'b1;
                  kind_nxt = REQ_EXIT;
               end
            end
            SQ_KEY1: begin
               if (key2) begin
                  st_nxt  = SQ_KEY2;
                  ev_read = 1'b0;
               end
            end
            SQ_KEY2: begin
               if (at_a && c_prog) begin
                  st_nxt  = SQ_ARMED;
                  ev_read = 1'b0;
               end else if (at_a && c_setup) begin
                  st_nxt  = SQ_ER3;
                  ev_read = 1'b0;
               end else if (at_a && c_id) begin
                  ev_read  = 1'b0;
                  ev_id    = 1'b1;
                  fire     = 1'b1;
                  kind_nxt = REQ_ID_ON;
               end else if (at_a && c_query) begin
                  ev_read  = 1'b0;
                  ev_query = 1'b1;
                  fire     = 1'b1;
                  kind_nxt = REQ_QUERY_ON;
               end else if (at_a && c_exit) begin
                  fire     = 1'b1;
                  kind_nxt = REQ_EXIT;
               end
            end
            SQ_ARMED: begin
               ev_read  = 1'b0;
               fire     = 1'b1;
               kind_nxt = REQ_PROGRAM;
            end
            SQ_ER3: begin
               if (key1) begin
                  st_nxt  = SQ_ER4;
                  ev_read = 1'b0;
               end
            end
            SQ_ER4: begin
               if (key2) begin
                  st_nxt  = SQ_ER5;
                  ev_read = 1'b0;
               end
            end
            SQ_ER5: begin
               if (at_a && c_chip) begin
                  ev_read  = 1'b0;
                  fire     = 1'b1;
                  kind_nxt = REQ_CHIP;
               end else if (c_sector) begin
                  ev_read  = 1'b0;
                  fire     = 1'b1;
                  kind_nxt = REQ_SECTOR;
                  addr_nxt = wr_addr & SEC_MASK;
               end else if (c_block) begin
                  ev_read  = 1'b0;
                  fire     = 1'b1;
                  kind_nxt = REQ_BLOCK;
                  addr_nxt = wr_addr & BLK_MASK;
               end
            end
            default: st_nxt = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         req_valid <= 1'b0;
         req_kind  <= REQ_NONE;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         st        <= st_nxt;
         req_valid <= fire;
         if (fire) begin
            req_kind <= kind_nxt;
            req_addr <= addr_nxt;
            req_data <= wr_data;
         end
      end
   end

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_valid) |=> ($stable(st) && !req_valid));

   // R12
   req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(wr_valid && !busy));

   // R5
   sector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == REQ_SECTOR) |-> (req_addr[SECTOR_BITS-1:0] == '0));

   // R6
   block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == REQ_BLOCK) |-> (req_addr[BLOCK_BITS-1:0] == '0));

   // R3
   program_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == REQ_PROGRAM) |-> $past(st == SQ_ARMED));

endmodule

// File: rtl/fcd_mode_track.sv
module fcd_mode_track
   import fcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_read,
   input  logic       ev_id,
   input  logic       ev_query,
   output logic [1:0] mode
);

   fl_mode_e cur;

   always_ff @(posedge clk) begin
      if (!rst_n)        cur <= MODE_READ;
      else if (ev_read)  cur <= MODE_READ;
      else if (ev_id)    cur <= MODE_ID;
      else if (ev_query) cur <= MODE_QUERY;
   end

   assign mode = cur;

   // R7
   mode_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_read, ev_id, ev_query}));

   // R9
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

endmodule

// File: rtl/fcd_id_port.sv
module fcd_id_port
   import fcd_pkg::*;
#(
   parameter int         AW         = 20,
   parameter logic [7:0] DEV_CODE   = 8'hD8,
   parameter bit         ID_OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic [AW-1:0] rd_addr,
   output logic          id_valid,
   output logic [7:0]    id_data
);

   logic       hit;
   logic [7:0] byte_sel;

   always_comb begin
      hit      = (mode == MODE_ID) && (rd_addr[AW-1:1] == '0);
      byte_sel = rd_addr[0] ? DEV_CODE : CODE_MFR;
      if (!hit) byte_sel = '0;
   end

   generate
      if (ID_OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               id_valid <= 1'b0;
               id_data  <= '0;
            end else begin
               id_valid <= hit;
               id_data  <= byte_sel;
            end
         end
      end else begin : g_comb
         assign id_valid = hit;
         assign id_data  = byte_sel;
      end
   endgenerate

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int         AW          = 20,
   parameter int         SECTOR_BITS = 12,
   parameter int         BLOCK_BITS  = 16,
   parameter logic [7:0] DEV_CODE    = 8'hD8,
   parameter bit         ID_OUT_REG  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          busy,
   input  logic [AW-1:0] rd_addr,
   output logic [1:0]    mode,
   output logic          req_valid,
   output logic [2:0]    req_kind,
   output logic [AW-1:0] req_addr,
   output logic [7:0]    req_data,
   output logic          id_valid,
   output logic [7:0]    id_data
);

   generate
      if (AW < CMP_BITS + 2 || AW > 32) begin : g_bad_aw
         $error("flash_cmd_decoder: AW out of range");
      end
      if (SECTOR_BITS >= BLOCK_BITS || BLOCK_BITS >= AW) begin : g_bad_geom
         $error("flash_cmd_decoder: sector/block geometry inconsistent");
      end
   endgenerate

   logic at_a, at_b, key1, key2;
   logic c_prog, c_setup, c_id, c_query, c_exit, c_chip, c_sector, c_block;
   logic ev_read, ev_id, ev_query;

   fcd_cycle_match #(.AW(AW)) u_match (
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .at_a    (at_a),
      .at_b    (at_b),
      .key1    (key1),
      .key2    (key2),
      .c_prog  (c_prog),
      .c_setup (c_setup),
      .c_id    (c_id),
      .c_query (c_query),
      .c_exit  (c_exit),
      .c_chip  (c_chip),
      .c_sector(c_sector),
      .c_block (c_block)
   );

   fcd_seq_fsm #(
      .AW         (AW),
      .SECTOR_BITS(SECTOR_BITS),
      .BLOCK_BITS (BLOCK_BITS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .busy     (busy),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .at_a     (at_a),
      .key1     (key1),
      .key2     (key2),
      .c_prog   (c_prog),
      .c_setup  (c_setup),
      .c_id     (c_id),
      .c_query  (c_query),
      .c_exit   (c_exit),
      .c_chip   (c_chip),
      .c_sector (c_sector),
      .c_block  (c_block),
      .ev_read  (ev_read),
      .ev_id    (ev_id),
      .ev_query (ev_query),
      .req_valid(req_valid),
      .req_kind (req_kind),
      .req_addr (req_addr),
      .req_data (req_data)
   );

   fcd_mode_track u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_read (ev_read),
      .ev_id   (ev_id),
      .ev_query(ev_query),
      .mode    (mode)
   );

   fcd_id_port #(
      .AW        (AW),
      .DEV_CODE  (DEV_CODE),
      .ID_OUT_REG(ID_OUT_REG)
   ) u_id (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .rd_addr (rd_addr),
      .id_valid(id_valid),
      .id_data (id_data)
   );

   // R8
   exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == REQ_EXIT) |-> (mode == MODE_READ));

   // R7
   id_on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == REQ_ID_ON) |-> (mode == MODE_ID));

   // R11
   id_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_ID) |-> !id_valid);

   // R10
   busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_valid) |=> $stable(mode));

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

   localparam int AW = 20;
   localparam logic [2:0] K_PROG = 3'd1, K_SEC = 3'd2, K_BLK = 3'd3, K_CHIP = 3'd4,
                          K_ID = 3'd5, K_QRY = 3'd6, K_EXIT = 3'd7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          busy = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [1:0]    mode;
   logic          req_valid;
   logic [2:0]    req_kind;
   logic [AW-1:0] req_addr;
   logic [7:0]    req_data;
   logic          id_valid;
   logic [7:0]    id_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic          s_v;
   logic [2:0]    s_k;
   logic [AW-1:0] s_a;
   logic [7:0]    s_d;
   logic [1:0]    s_m;

   always #2 clk = ~clk;

   flash_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr), .mode(mode),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_data(req_data), .id_valid(id_valid), .id_data(id_data)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one write; outputs are sampled at the following falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      s_v = req_valid; s_k = req_kind; s_a = req_addr; s_d = req_data; s_m = mode;
   endtask

   task automatic unlock();
      wr(20'h05555, 8'hAA);
      wr(20'h02AAA, 8'h55);
   endtask

   task automatic erase_prefix();
      unlock();
      wr(20'h05555, 8'h80);
      wr(20'h05555, 8'hAA);
      wr(20'h02AAA, 8'h55);
   endtask

   task automatic t_reset();
      check("R1 mode", mode, 0);
      check("R1 req_valid", req_valid, 0);
      check("R1 id_valid", id_valid, 0);
   endtask

   task automatic t_program();
      wr(20'hF5555, 8'hAA);
      check("R2 no req after key1", s_v, 0);
      wr(20'h32AAA, 8'h55);
      wr(20'hA5555, 8'hA0);
      check("R2 no req while armed", s_v, 0);
      wr(20'hABCDE, 8'h3C);
      check("R3 valid", s_v, 1);
      check("R3 kind", s_k, K_PROG);
      check("R3 addr", s_a, 20'hABCDE);
      check("R3 data", s_d, 8'h3C);
      @(negedge clk);
      check("R12 single cycle", req_valid, 0);
   endtask

   task automatic t_chip();
      erase_prefix();
      check("R4 no req in prefix", s_v, 0);
      wr(20'h05555, 8'h10);
      check("R4 valid", s_v, 1);
      check("R4 kind", s_k, K_CHIP);
      check("R4 mode", s_m, 0);
   endtask

   task automatic t_sector();
      erase_prefix();
      wr(20'h7A5F3, 8'h30);
      check("R5 kind", s_k, K_SEC);
      check("R5 addr", s_a, 20'h7A000);
   endtask

   task automatic t_block();
      erase_prefix();
      wr(20'h7A5F3, 8'h50);
      check("R6 kind", s_k, K_BLK);
      check("R6 addr", s_a, 20'h70000);
   endtask

   task automatic t_id();
      unlock();
      wr(20'h05555, 8'h90);
      check("R7 id kind", s_k, K_ID);
      check("R7 id mode", s_m, 1);
      rd_addr = 20'h0; #1;
      check("R11 mfr valid", id_valid, 1);
      check("R11 mfr byte", id_data, 8'hBF);
      rd_addr = 20'h1; #1;
      check("R11 dev byte", id_data, 8'hD8);
      rd_addr = 20'h2; #1;
      check("R11 other addr", id_valid, 0);
      wr(20'h12345, 8'hF0);
      check("R8 lone exit kind", s_k, K_EXIT);
      check("R8 lone exit mode", s_m, 0);
      rd_addr = 20'h0; #1;
      check("R11 read mode no id", id_valid, 0);
   endtask

   task automatic t_query();
      unlock();
      wr(20'h05555, 8'h98);
      check("R7 query kind", s_k, K_QRY);
      check("R7 query mode", s_m, 2);
      unlock();
      check("R8 mode kept in prefix", s_m, 2);
      wr(20'h05555, 8'hF0);
      check("R8 long exit kind", s_k, K_EXIT);
      check("R8 long exit mode", s_m, 0);
   endtask

   task automatic t_abort();
      unlock();
      wr(20'h05555, 8'h90);
      wr(20'h05555, 8'hAA);
      wr(20'h02AAA, 8'h56);
      check("R9 bad data no req", s_v, 0);
      check("R9 bad data mode", s_m, 0);
      unlock();
      wr(20'h05555, 8'h90);
      wr(20'h01555, 8'hAA);
      check("R2 bit14 compared", s_m, 0);
      erase_prefix();
      wr(20'h02AAB, 8'h55);
      check("R9 bad addr no req", s_v, 0);
      erase_prefix();
      wr(20'h05555, 8'h10);
      check("R9 restart works", s_k, K_CHIP);
   endtask

   task automatic t_busy();
      unlock();
      wr(20'h05555, 8'h90);
      busy = 1'b1;
      wr(20'h00000, 8'hF0);
      check("R10 exit ignored no req", s_v, 0);
      check("R10 exit ignored mode", s_m, 1);
      busy = 1'b0;
      unlock();
      busy = 1'b1;
      wr(20'h00777, 8'h13);
      check("R10 junk ignored mode", s_m, 1);
      busy = 1'b0;
      wr(20'h05555, 8'hA0);
      wr(20'h44444, 8'h99);
      check("R10 sequence survived kind", s_k, K_PROG);
      check("R10 sequence survived data", s_d, 8'h99);
      check("R10 sequence survived valid", s_v, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_program();
      t_chip();
      t_sector();
      t_block();
      t_id();
      t_query();
      t_abort();
      t_busy();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule